// File: doc/BRIEF.md
# Boot Handshake Mailbox Register Block

This block is the meeting point between a host processor and the boot firmware of a subsystem during bring-up. The host reaches it over a plain 32-bit register bus. Through it, the host places the address of the loader image, the address of the image metadata, the start address of the code and a running code length. It also issues two handshake commands: metadata-ready and then load-ready. The subsystem side sees every pointer and the last accepted command as plain outputs. It gets a single-cycle pulse for each accepted command, and it posts progress codes into a boot-ROM status word and a loader status word, which the host polls.

The block enforces the handshake order. A load-ready command that comes before any metadata-ready is dropped and latches a sticky protocol-error flag that the host can read. The code start address can only be set while the code length is zero. This matches the host flow: the length is cleared first, the start address and load-ready are issued, and then the length is grown segment by segment.

Top module: `boot_mailbox_regs`

## Requirements
- R1: After reset, every register reads 0, `cmdPulse` is 0, `cmdValue` is 0 and the protocol-error flag is clear.
- R2: Host word registers are selected by `busAddr[7:2]`, and bits [1:0] are ignored. Index 0 (byte 0x00) is the image address, 4 (0x10) the metadata address, 5 (0x14) the code start and 6 (0x18) the code length. Read data appears on `busRdData` in the cycle after the clock edge that samples `busRdEn`.
- R3: A write of 1 (metadata-ready) to index 2 (0x08) is always accepted. A write of 2 (load-ready) is accepted once metadata-ready has been accepted since reset. An accepted command sets `cmdValue` and reads back at 0x08 from the next edge, and it raises `cmdPulse` for exactly the one cycle after that edge.
- R4: A load-ready written before any accepted metadata-ready gives no pulse and leaves `cmdValue` unchanged. It sets the protocol-error flag, which reads as bit 0 at index 7 (0x1C). The flag stays set until reset.
- R5: A write to 0x08 of any value other than 1 or 2 gives no pulse and leaves `cmdValue` and the error flag unchanged.
- R6: A host write to the code start register is ignored while the code length register is nonzero.
- R7: The code length register stores each value written, so the host's running sum reads back. Writing 0 reopens the code start register for writing.
- R8: The boot-ROM status (index 1, 0x04) and loader status (index 3, 0x0C) take host writes and subsystem posts. When both arrive in the same cycle, the subsystem value is stored.
- R9: Writes to index 7 and to any address at or above 0x20 change nothing. Reads of addresses at or above 0x20 return 0.
- R10: The subsystem outputs `imageAddr`, `metaAddr`, `codeStart`, `codeLen`, `romStatus` and `ldrStatus` show the stored register values from the edge that stores them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Host byte address |
| busWrEn | input | 1 | Host write strobe |
| busWrData | input | 32 | Host write data |
| busRdEn | input | 1 | Host read strobe |
| busRdData | output | 32 | Registered read data |
| romStatusWr | input | 1 | Subsystem post to boot-ROM status |
| romStatusIn | input | 32 | Boot-ROM status value posted |
| ldrStatusWr | input | 1 | Subsystem post to loader status |
| ldrStatusIn | input | 32 | Loader status value posted |
| cmdPulse | output | 1 | One-cycle pulse per accepted command |
| cmdValue | output | 32 | Last accepted command |
| imageAddr | output | 32 | Loader image address |
| metaAddr | output | 32 | Metadata address |
| codeStart | output | 32 | Code start address |
| codeLen | output | 32 | Running code length |
| romStatus | output | 32 | Boot-ROM status word |
| ldrStatus | output | 32 | Loader status word |

## Verification
The order tracker is the main risk. If its "metadata seen" state is wrong, the first load-ready either pulses `cmdPulse` when it should not, or sets the error flag when it should not. Either shows at the ports on the edge that takes the write. The start-address lock depends on the live code length. A stale comparison would let a late start write through, and that shows on `codeStart` one edge after the write. The status priority is tested with a post and a host write in the same cycle, so a wrong ordering shows in the next read.

// File: rtl/bootmb_pkg.sv
package bootmb_pkg;

  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_IMAGE = 3'd0,
    IDX_ROMST = 3'd1,
    IDX_CMD   = 3'd2,
    IDX_LDRST = 3'd3,
    IDX_META  = 3'd4,
    IDX_START = 3'd5,
    IDX_LEN   = 3'd6,
    IDX_ERR   = 3'd7
  } regIdx_e;

  localparam int CMD_META = 1;
  localparam int CMD_LOAD = 2;

  localparam int NUM_PTR = 4;
  localparam int PTR_IMAGE = 0;
  localparam int PTR_META  = 1;
  localparam int PTR_START = 2;
  localparam int PTR_LEN   = 3;

  typedef struct packed {
    logic wrImage;
    logic wrRom;
    logic wrLdr;
    logic wrMeta;
    logic wrStart;
    logic wrLen;
    logic cmdTake;
    logic rdStrobe;
    logic rdHit;
  } strobe_t;

endpackage

// File: rtl/bootmb_ctrl.sv
module bootmb_ctrl
  import bootmb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  input  logic              codeLenZero,
  output strobe_t           st,
  output regIdx_e           regSel,
  output logic              cmdPulse,
  output logic              protoErr
);

  localparam int HI_W = ADDR_W - 2 - IDX_W;

  logic    mapped;
  logic    metaSeen;
  logic    isCmd;
  logic    cmdMeta;
  logic    cmdLoad;
  logic    acceptCmd;
  logic    rejectCmd;

  assign mapped = (busAddr[ADDR_W-1:2+IDX_W] == HI_W'(0));
  assign regSel = regIdx_e'(busAddr[2+IDX_W-1:2]);

  assign isCmd   = busWrEn && mapped && (regSel == IDX_CMD);
  assign cmdMeta = isCmd && (busWrData == DATA_W'(CMD_META));
  assign cmdLoad = isCmd && (busWrData == DATA_W'(CMD_LOAD));

  assign acceptCmd = cmdMeta || (cmdLoad && metaSeen);
  assign rejectCmd = cmdLoad && !metaSeen;

  always_comb begin
    st          = '0;
    st.rdStrobe = busRdEn;
    st.rdHit    = mapped;
    st.cmdTake  = acceptCmd;
    if (busWrEn && mapped) begin
      unique case (regSel)
        IDX_IMAGE: st.wrImage = 1'b1;
        IDX_ROMST: st.wrRom   = 1'b1;
        IDX_LDRST: st.wrLdr   = 1'b1;
        IDX_META:  st.wrMeta  = 1'b1;
        IDX_START: st.wrStart = codeLenZero;
        IDX_LEN:   st.wrLen   = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaSeen <= 1'b0;
      protoErr <= 1'b0;
      cmdPulse <= 1'b0;
    end else begin
      cmdPulse <= acceptCmd;
      if (cmdMeta) metaSeen <= 1'b1;
      if (rejectCmd) protoErr <= 1'b1;
    end
  end

endmodule

// File: rtl/bootmb_datapath.sv
module bootmb_datapath
  import bootmb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  regIdx_e           regSel,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              romStatusWr,
  input  logic [DATA_W-1:0] romStatusIn,
  input  logic              ldrStatusWr,
  input  logic [DATA_W-1:0] ldrStatusIn,
  input  logic              protoErr,
  output logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] cmdValue,
  output logic [DATA_W-1:0] imageAddr,
  output logic [DATA_W-1:0] metaAddr,
  output logic [DATA_W-1:0] codeStart,
  output logic [DATA_W-1:0] codeLen,
  output logic [DATA_W-1:0] romStatus,
  output logic [DATA_W-1:0] ldrStatus,
  output logic              codeLenZero
);

  logic [NUM_PTR-1:0] ptrWe;
  logic [DATA_W-1:0]  ptrQ [NUM_PTR];
  logic [DATA_W-1:0]  rdNext;

  assign ptrWe[PTR_IMAGE] = st.wrImage;
  assign ptrWe[PTR_META]  = st.wrMeta;
  assign ptrWe[PTR_START] = st.wrStart;
  assign ptrWe[PTR_LEN]   = st.wrLen;

  for (genvar g = 0; g < NUM_PTR; g++) begin : gPtr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         ptrQ[g] <= '0;
      else if (ptrWe[g]) ptrQ[g] <= busWrData;
    end
  end

  assign imageAddr   = ptrQ[PTR_IMAGE];
  assign metaAddr    = ptrQ[PTR_META];
  assign codeStart   = ptrQ[PTR_START];
  assign codeLen     = ptrQ[PTR_LEN];
  assign codeLenZero = (ptrQ[PTR_LEN] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romStatus <= '0;
      ldrStatus <= '0;
      cmdValue  <= '0;
    end else begin
      if (romStatusWr)   romStatus <= romStatusIn;
      else if (st.wrRom) romStatus <= busWrData;
      if (ldrStatusWr)   ldrStatus <= ldrStatusIn;
      else if (st.wrLdr) ldrStatus <= busWrData;
      if (st.cmdTake)    cmdValue  <= busWrData;
    end
  end

  always_comb begin
    rdNext = '0;
    if (st.rdHit) begin
      unique case (regSel)
        IDX_IMAGE: rdNext = ptrQ[PTR_IMAGE];
        IDX_ROMST: rdNext = romStatus;
        IDX_CMD:   rdNext = cmdValue;
        IDX_LDRST: rdNext = ldrStatus;
        IDX_META:  rdNext = ptrQ[PTR_META];
        IDX_START: rdNext = ptrQ[PTR_START];
        IDX_LEN:   rdNext = ptrQ[PTR_LEN];
        IDX_ERR:   rdNext = DATA_W'(protoErr);
        default:   rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            busRdData <= '0;
    else if (st.rdStrobe) busRdData <= rdNext;
  end

endmodule

// File: rtl/boot_mailbox_regs.sv
module boot_mailbox_regs
  import bootmb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              romStatusWr,
  input  logic [DATA_W-1:0] romStatusIn,
  input  logic              ldrStatusWr,
  input  logic [DATA_W-1:0] ldrStatusIn,
  output logic              cmdPulse,
  output logic [DATA_W-1:0] cmdValue,
  output logic [DATA_W-1:0] imageAddr,
  output logic [DATA_W-1:0] metaAddr,
  output logic [DATA_W-1:0] codeStart,
  output logic [DATA_W-1:0] codeLen,
  output logic [DATA_W-1:0] romStatus,
  output logic [DATA_W-1:0] ldrStatus
);

  strobe_t st;
  regIdx_e regSel;
  logic    protoErr;
  logic    codeLenZero;

  bootmb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busAddr     (busAddr),
    .busWrEn     (busWrEn),
    .busWrData   (busWrData),
    .busRdEn     (busRdEn),
    .codeLenZero (codeLenZero),
    .st          (st),
    .regSel      (regSel),
    .cmdPulse    (cmdPulse),
    .protoErr    (protoErr)
  );

  bootmb_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .regSel      (regSel),
    .busWrData   (busWrData),
    .romStatusWr (romStatusWr),
    .romStatusIn (romStatusIn),
    .ldrStatusWr (ldrStatusWr),
    .ldrStatusIn (ldrStatusIn),
    .protoErr    (protoErr),
    .busRdData   (busRdData),
    .cmdValue    (cmdValue),
    .imageAddr   (imageAddr),
    .metaAddr    (metaAddr),
    .codeStart   (codeStart),
    .codeLen     (codeLen),
    .romStatus   (romStatus),
    .ldrStatus   (ldrStatus),
    .codeLenZero (codeLenZero)
  );

endmodule

// File: rtl/boot_mailbox_checker.sv
module boot_mailbox_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              cmdPulse,
  input logic [DATA_W-1:0] cmdValue,
  input logic              protoErr,
  input logic [DATA_W-1:0] codeLen,
  input logic [DATA_W-1:0] codeStart,
  input logic              romStatusWr,
  input logic [DATA_W-1:0] romStatusIn,
  input logic [DATA_W-1:0] romStatus,
  input logic              ldrStatusWr,
  input logic [DATA_W-1:0] ldrStatusIn,
  input logic [DATA_W-1:0] ldrStatus
);

  AST_PULSE_FROM_CMD_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    cmdPulse |-> ($past(busWrEn) && ($past(busAddr[ADDR_W-1:2]) == (ADDR_W-2)'(2)))); // R3

  AST_CMD_HELD_WITHOUT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !cmdPulse |-> $stable(cmdValue)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr); // R4

  AST_ERR_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protoErr) |-> !cmdPulse); // R4

  AST_START_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (codeLen != '0) |=> $stable(codeStart)); // R6

  AST_ROM_POST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    romStatusWr |=> (romStatus == $past(romStatusIn))); // R8

  AST_LDR_POST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ldrStatusWr |=> (ldrStatus == $past(ldrStatusIn))); // R8

endmodule

bind boot_mailbox_regs boot_mailbox_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWrEn     (busWrEn),
  .cmdPulse    (cmdPulse),
  .cmdValue    (cmdValue),
  .protoErr    (protoErr),
  .codeLen     (codeLen),
  .codeStart   (codeStart),
  .romStatusWr (romStatusWr),
  .romStatusIn (romStatusIn),
  .romStatus   (romStatus),
  .ldrStatusWr (ldrStatusWr),
  .ldrStatusIn (ldrStatusIn),
  .ldrStatus   (ldrStatus)
);

// File: tb/test_boot_mailbox_regs.sv
`timescale 1ns/1ps
module test_boot_mailbox_regs;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] expect_;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 32'h8000_1000, 32'h8000_1000, 8'd2},  // R2 image
    '{8'h10, 32'h8100_0000, 32'h8100_0000, 8'd2},  // R2 metadata
    '{8'h18, 32'h0000_0000, 32'h0000_0000, 8'd7},  // R7 clear length
    '{8'h14, 32'h8200_0000, 32'h8200_0000, 8'd7},  // R7 start open
    '{8'h18, 32'h0000_0100, 32'h0000_0100, 8'd7},  // R7 first segment
    '{8'h14, 32'hDEAD_0000, 32'h8200_0000, 8'd6},  // R6 start locked
    '{8'h1A, 32'h0000_0340, 32'h0000_0340, 8'd7},  // R7 running sum, R2 low bits
    '{8'h03, 32'h1234_5678, 32'h1234_5678, 8'd2},  // R2 low bits ignored
    '{8'h24, 32'hFFFF_FFFF, 32'h0000_0000, 8'd9},  // R9 unmapped
    '{8'h1C, 32'h0000_0001, 32'h0000_0000, 8'd9}   // R9 error word read-only
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [DATA_W-1:0] busWrData = '0;
  logic              busRdEn = 1'b0;
  logic [DATA_W-1:0] busRdData;
  logic              romStatusWr = 1'b0;
  logic [DATA_W-1:0] romStatusIn = '0;
  logic              ldrStatusWr = 1'b0;
  logic [DATA_W-1:0] ldrStatusIn = '0;
  logic              cmdPulse;
  logic [DATA_W-1:0] cmdValue, imageAddr, metaAddr, codeStart, codeLen, romStatus, ldrStatus;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  boot_mailbox_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_boot_mailbox_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(busRdData), .romStatusWr(romStatusWr), .romStatusIn(romStatusIn),
    .ldrStatusWr(ldrStatusWr), .ldrStatusIn(ldrStatusIn), .cmdPulse(cmdPulse), .cmdValue(cmdValue),
    .imageAddr(imageAddr), .metaAddr(metaAddr), .codeStart(codeStart), .codeLen(codeLen),
    .romStatus(romStatus), .ldrStatus(ldrStatus)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check("R1 pulse", 32'(cmdPulse), 32'h0);
    for (int i = 0; i < 8; i++) begin
      busRead(8'(i * 4), rd);
      check("R1 reg", rd, 32'h0);
    end

    // Table walk: R2, R6, R7, R9
    for (int v = 0; v < NVEC; v++) begin
      busWrite(VECS[v].addr, VECS[v].data);
      busRead(VECS[v].addr, rd);
      check($sformatf("R%0d vec%0d", VECS[v].req, v), rd, VECS[v].expect_);
    end

    // R10: subsystem view of pointers
    check("R10 image", imageAddr, 32'h1234_5678);
    check("R10 meta", metaAddr, 32'h8100_0000);
    check("R10 start", codeStart, 32'h8200_0000);
    check("R10 len", codeLen, 32'h0000_0340);

    // R7: clearing length reopens start
    busWrite(8'h18, 32'h0);
    busWrite(8'h14, 32'h9000_0000);
    check("R7 reopen", codeStart, 32'h9000_0000);

    // R5: unknown command ignored
    busWrite(8'h08, 32'h7);
    check("R5 pulse", 32'(cmdPulse), 32'h0);
    check("R5 value", cmdValue, 32'h0);
    busRead(8'h1C, rd);
    check("R5 err", rd, 32'h0);

    // R4: load-ready before metadata-ready
    busWrite(8'h08, 32'h2);
    check("R4 pulse", 32'(cmdPulse), 32'h0);
    check("R4 value", cmdValue, 32'h0);
    busRead(8'h1C, rd);
    check("R4 err set", rd, 32'h1);

    // R3: metadata-ready then load-ready
    busWrite(8'h08, 32'h1);
    check("R3 pulse meta", 32'(cmdPulse), 32'h1);
    check("R3 value meta", cmdValue, 32'h1);
    @(negedge clk);
    check("R3 pulse width", 32'(cmdPulse), 32'h0);
    busWrite(8'h08, 32'h2);
    check("R3 pulse load", 32'(cmdPulse), 32'h1);
    busRead(8'h08, rd);
    check("R3 readback", rd, 32'h2);
    busRead(8'h1C, rd);
    check("R4 sticky", rd, 32'h1);

    // R8: status posts and priority
    @(negedge clk);
    romStatusWr = 1'b1; romStatusIn = 32'h1;
    @(negedge clk);
    romStatusWr = 1'b0;
    busRead(8'h04, rd);
    check("R8 rom post", rd, 32'h1);
    check("R10 rom out", romStatus, 32'h1);
    @(negedge clk);
    busAddr = 8'h0C; busWrData = 32'h0; busWrEn = 1'b1;
    ldrStatusWr = 1'b1; ldrStatusIn = 32'h8000_0005;
    @(negedge clk);
    busWrEn = 1'b0; ldrStatusWr = 1'b0;
    busRead(8'h0C, rd);
    check("R8 ldr priority", rd, 32'h8000_0005);
    busWrite(8'h04, 32'h0);
    busRead(8'h04, rd);
    check("R8 host write", rd, 32'h0);

    // R1: reset clears everything again
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    busRead(8'h1C, rd);
    check("R1 err cleared", rd, 32'h0);
    check("R1 cmd cleared", cmdValue, 32'h0);

    finish_run();
  end

endmodule